// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This unit turns one IEEE-754 binary16 or binary32 value into a 16-bit or 32-bit fixed-point integer, either signed or unsigned. The number of fraction bits can be set for each operation. Each request is accepted on a valid strobe and answered one clock later from a single output register stage.

The fraction count is not given directly. It comes as a 5-bit immediate that holds the fixed-point width minus the fraction bits. The conversion always truncates toward zero, whatever rounding mode the surrounding unit uses. The result fills the whole 32-bit destination word: signed results are sign-extended and unsigned results are zero-extended.

Three flags report what happened. An out-of-range value or a NaN saturates and raises the invalid flag. Discarded nonzero bits raise the inexact flag. An immediate that implies a negative fraction count raises the illegal flag and blocks the write.

Top module: `fxc_conv`

## Requirements
- R1: Conversion truncates toward zero. When nonzero bits are discarded and the result is not saturated, inexact_o is 1 (for example, 1.75 with 0 fraction bits gives 1 and -1.75 gives -1, both with inexact_o = 1).
- R2: wide_i = 0 selects a 16-bit fixed-point result and wide_i = 1 selects a 32-bit result.
- R3: unsigned_i = 0 selects signed fixed point and unsigned_i = 1 selects unsigned fixed point.
- R4: The fraction count is (16 when wide_i = 0, 32 when wide_i = 1) minus the unsigned value of imm_i[4:0]. The result equals the input times 2 to the power of that count, truncated.
- R5: When wide_i = 0 and imm_i > 16, the operation is illegal. illegal_o = 1, wr_en_o = 0, invalid_o = inexact_o = 0, and dst_o keeps its previous value.
- R6: A 16-bit signed result is sign-extended into dst_o[31:16]. A 16-bit unsigned result has dst_o[31:16] = 0.
- R7: prec_i = 0 selects binary16 taken from src_i[15:0], and src_i[31:16] is ignored. prec_i = 1 selects binary32 from src_i[31:0].
- R8: A value above the largest code, including +infinity, gives the largest code (0x7FFF, 0x7FFFFFFF, 0xFFFF or 0xFFFFFFFF before extension). A value below the smallest signed code, including -infinity, gives 0x8000 or 0x80000000. Both set invalid_o = 1 and inexact_o = 0.
- R9: A NaN gives 0 with invalid_o = 1. In unsigned mode, a negative input whose truncated magnitude is nonzero gives 0 with invalid_o = 1. A negative input that truncates to 0 gives 0 with only inexact_o = 1.
- R10: Zero and subnormal inputs convert without invalid_o. A subnormal gives either an exact small value or zero with inexact_o = 1, depending on the fraction count.
- R11: valid_o is valid_i delayed by one clock. Results and flags appear in that same cycle. wr_en_o = 1 exactly for valid, legal operations. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| src_i | input | 32 | Source word holding the floating-point operand |
| prec_i | input | 1 | 0: binary16 in bits 15:0, 1: binary32 |
| unsigned_i | input | 1 | 0: signed result, 1: unsigned result |
| wide_i | input | 1 | 0: 16-bit result, 1: 32-bit result |
| imm_i | input | 5 | Width minus fraction count |
| valid_o | output | 1 | Response strobe, one clock after valid_i |
| wr_en_o | output | 1 | Result written to dst_o |
| dst_o | output | 32 | Extended fixed-point result |
| illegal_o | output | 1 | Negative fraction count |
| invalid_o | output | 1 | Saturation or NaN |
| inexact_o | output | 1 | Nonzero bits discarded |

## Verification
The properties assume that src_i, prec_i, unsigned_i, wide_i and imm_i are stable and meaningful whenever valid_i is high, because several checks key on the values those inputs held one cycle before the response. The bench drives every field together on a falling edge with valid_i high for exactly one clock, then drops valid_i. The strobe is therefore never high with stale operands. Illegal immediates are applied only in 16-bit mode, the one mode where such a value is possible.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  localparam int MANT_W = 24;          // hidden bit + binary32 fraction
  localparam int EXP_W  = 10;
  localparam int SH_W   = 11;
  localparam int MAG_W  = 64;
  localparam int DST_W  = 32;
  localparam int HALF_W = DST_W / 2;
  localparam int SH_CAP = MAG_W - MANT_W;
  localparam int FBIAS  = MANT_W - 1;

  typedef struct packed {
    logic              sign;
    logic              is_nan;
    logic              is_inf;
    logic [EXP_W-1:0]  exp;   // unbiased, two's complement
    logic [MANT_W-1:0] mant;  // hidden bit at MSB
  } fxc_unp_t;
endpackage

// File: rtl/fxc_unpack.sv
module fxc_unpack
  import fxc_pkg::*;
(
  input  logic [DST_W-1:0] src_i,
  input  logic             prec_i,
  output fxc_unp_t         unp_o
);
  logic [7:0]  e8;
  logic [22:0] m23;
  logic [4:0]  e5;
  logic [9:0]  m10;

  assign e8  = src_i[30:23];
  assign m23 = src_i[22:0];
  assign e5  = src_i[14:10];
  assign m10 = src_i[9:0];

  always_comb begin
    if (prec_i) begin
      unp_o.sign   = src_i[31];
      unp_o.is_nan = (&e8) && (|m23);
      unp_o.is_inf = (&e8) && !(|m23);
      unp_o.exp    = (e8 == '0) ? -EXP_W'(126) : EXP_W'(e8) - EXP_W'(127);
      unp_o.mant   = {|e8, m23};
    end else begin
      unp_o.sign   = src_i[15];
      unp_o.is_nan = (&e5) && (|m10);
      unp_o.is_inf = (&e5) && !(|m10);
      unp_o.exp    = (e5 == '0) ? -EXP_W'(14) : EXP_W'(e5) - EXP_W'(15);
      unp_o.mant   = {|e5, m10, 13'b0};
    end
  end
endmodule

// File: rtl/fxc_shift.sv
module fxc_shift
  import fxc_pkg::*;
(
  input  logic [MANT_W-1:0] mant_i,
  input  logic [SH_W-1:0]   sh_i,     // signed left-shift amount
  output logic [MAG_W-1:0]  mag_o,
  output logic              big_o,    // magnitude beyond MAG_W
  output logic              sticky_o
);
  logic [SH_W-1:0] rs;

  always_comb begin
    mag_o    = '0;
    big_o    = 1'b0;
    sticky_o = 1'b0;
    rs       = -sh_i;
    if (!sh_i[SH_W-1] && (sh_i > SH_W'(SH_CAP))) begin
      big_o = |mant_i;
    end else if (!sh_i[SH_W-1]) begin
      mag_o = MAG_W'(mant_i) << sh_i[5:0];
    end else if (rs >= SH_W'(MANT_W)) begin
      sticky_o = |mant_i;
    end else begin
      mag_o    = MAG_W'(mant_i >> rs[4:0]);
      sticky_o = |(mant_i & ((MANT_W'(1) << rs[4:0]) - MANT_W'(1)));
    end
  end
endmodule

// File: rtl/fxc_range.sv
module fxc_range
  import fxc_pkg::*;
(
  input  fxc_unp_t          unp_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              big_i,
  input  logic              wide_i,
  input  logic              unsigned_i,
  output logic [DST_W-1:0]  res_o,
  output logic              ovf_o
);
  logic [MAG_W-1:0] lim_pos, lim_neg, val;
  logic             huge;

  assign huge = unp_i.is_inf | big_i;

  always_comb begin
    lim_pos = wide_i ? MAG_W'(64'hFFFF_FFFF) : MAG_W'(64'hFFFF);
    if (!unsigned_i) lim_pos = lim_pos >> 1;
    lim_neg = unsigned_i ? '0 : (wide_i ? MAG_W'(64'h8000_0000) : MAG_W'(64'h8000));
    ovf_o   = 1'b0;
    if (unp_i.is_nan) begin
      val   = '0;
      ovf_o = 1'b1;
    end else if (unp_i.sign) begin
      if (huge || (mag_i > lim_neg)) begin
        val   = -lim_neg;
        ovf_o = 1'b1;
      end else begin
        val = -mag_i;
      end
    end else if (huge || (mag_i > lim_pos)) begin
      val   = lim_pos;
      ovf_o = 1'b1;
    end else begin
      val = mag_i;
    end
  end

  always_comb begin
    if (wide_i)          res_o = val[DST_W-1:0];
    else if (unsigned_i) res_o = {{HALF_W{1'b0}}, val[HALF_W-1:0]};
    else                 res_o = {{HALF_W{val[HALF_W-1]}}, val[HALF_W-1:0]};
  end
endmodule

// File: rtl/fxc_conv.sv
module fxc_conv
  import fxc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DST_W-1:0] src_i,
  input  logic             prec_i,
  input  logic             unsigned_i,
  input  logic             wide_i,
  input  logic [4:0]       imm_i,
  output logic             valid_o,
  output logic             wr_en_o,
  output logic [DST_W-1:0] dst_o,
  output logic             illegal_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  fxc_unp_t         unp;
  logic [5:0]       frac;
  logic             bad_enc;
  logic [SH_W-1:0]  sh;
  logic [MAG_W-1:0] mag;
  logic             big, sticky, ovf;
  logic [DST_W-1:0] res;

  assign bad_enc = !wide_i && (imm_i > 5'd16);
  assign frac    = (wide_i ? 6'd32 : 6'd16) - {1'b0, imm_i};
  assign sh      = {unp.exp[EXP_W-1], unp.exp} - SH_W'(FBIAS) + SH_W'(frac);

  fxc_unpack u_unpack (
    .src_i  (src_i),
    .prec_i (prec_i),
    .unp_o  (unp)
  );

  fxc_shift u_shift (
    .mant_i   (unp.mant),
    .sh_i     (sh),
    .mag_o    (mag),
    .big_o    (big),
    .sticky_o (sticky)
  );

  fxc_range u_range (
    .unp_i      (unp),
    .mag_i      (mag),
    .big_i      (big),
    .wide_i     (wide_i),
    .unsigned_i (unsigned_i),
    .res_o      (res),
    .ovf_o      (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      dst_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= valid_i && !bad_enc;
      illegal_o <= valid_i && bad_enc;
      invalid_o <= valid_i && !bad_enc && ovf;
      inexact_o <= valid_i && !bad_enc && !ovf && sticky;
      if (valid_i && !bad_enc) dst_o <= res;
    end
  end
endmodule

// File: rtl/fxc_conv_chk.sv
module fxc_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] src_i,
  input logic        prec_i,
  input logic        unsigned_i,
  input logic        wide_i,
  input logic [4:0]  imm_i,
  input logic        valid_o,
  input logic        wr_en_o,
  input logic [31:0] dst_o,
  input logic        illegal_o,
  input logic        invalid_o,
  input logic        inexact_o
);
  logic legal_req;
  assign legal_req = valid_i && !(!wide_i && (imm_i > 5'd16));

  assert_valid_delay_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_write_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (valid_o && !illegal_o));
  assert_illegal_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && !wr_en_o && !invalid_o && !inexact_o));
  assert_hold_dst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> (dst_o == $past(dst_o)));
  assert_flag_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !inexact_o);
  assert_sign_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_req && !wide_i && !unsigned_i) |=> (dst_o[31:16] == {16{dst_o[15]}}));
  assert_zero_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_req && !wide_i && unsigned_i) |=> (dst_o[31:16] == 16'h0));
  assert_uns_neg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_req && unsigned_i && (prec_i ? src_i[31] : src_i[15])) |=> (dst_o == 32'h0));
endmodule

bind fxc_conv fxc_conv_chk chk_i (.*);

// File: tb/fxc_conv_tb_top.sv
module fxc_conv_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] src_i = '0;
  logic        prec_i = 1'b0;
  logic        unsigned_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [4:0]  imm_i = '0;
  logic        valid_o, wr_en_o, illegal_o, invalid_o, inexact_o;
  logic [31:0] dst_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fxc_conv dut_i (.*);

  task automatic chk(string tag, logic [31:0] exp_dst, logic exp_wr, logic exp_ill,
                     logic exp_inv, logic exp_inx);
    n_checks++;
    if (dst_o !== exp_dst || wr_en_o !== exp_wr || illegal_o !== exp_ill ||
        invalid_o !== exp_inv || inexact_o !== exp_inx || valid_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: dst=%h wr=%b ill=%b inv=%b inx=%b vld=%b expected dst=%h wr=%b ill=%b inv=%b inx=%b vld=1",
               tag, dst_o, wr_en_o, illegal_o, invalid_o, inexact_o, valid_o,
               exp_dst, exp_wr, exp_ill, exp_inv, exp_inx);
    end
  endtask

  task automatic conv(logic [31:0] s, logic p, logic u, logic w, logic [4:0] im);
    @(negedge clk_i);
    src_i = s; prec_i = p; unsigned_i = u; wide_i = w; imm_i = im; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    n_checks++;
    if (valid_o !== 1'b0 || wr_en_o !== 1'b0 || dst_o !== 32'h0 || illegal_o !== 1'b0 ||
        invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: vld=%b wr=%b dst=%h expected all zero", valid_o, wr_en_o, dst_o);
    end
  endtask

  task automatic t_basic;
    conv(32'h3FC00000, 1, 0, 0, 5'd8);  chk("R4 1.5 s16 f8", 32'h00000180, 1, 0, 0, 0);
    conv(32'hC0300000, 1, 0, 1, 5'd28); chk("R2 -2.75 s32 f4", 32'hFFFFFFD4, 1, 0, 0, 0);
    conv(32'h40400000, 1, 0, 1, 5'd31); chk("R4 3.0 s32 f1", 32'h00000006, 1, 0, 0, 0);
    @(negedge clk_i);
    n_checks++;
    if (valid_o !== 1'b0 || wr_en_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 idle: vld=%b wr=%b expected 0 0", valid_o, wr_en_o);
    end
  endtask

  task automatic t_trunc;
    conv(32'h3FE00000, 1, 0, 0, 5'd16); chk("R1 1.75 trunc", 32'h00000001, 1, 0, 0, 1);
    conv(32'hBFE00000, 1, 0, 0, 5'd16); chk("R1 -1.75 trunc", 32'hFFFFFFFF, 1, 0, 0, 1);
  endtask

  task automatic t_sat;
    conv(32'h4788B800, 1, 1, 0, 5'd16); chk("R8 70000 u16", 32'h0000FFFF, 1, 0, 1, 0);
    conv(32'hC71C4000, 1, 0, 0, 5'd16); chk("R8 -40000 s16", 32'hFFFF8000, 1, 0, 1, 0);
    conv(32'hC7000000, 1, 0, 0, 5'd16); chk("R8 -32768 s16 exact", 32'hFFFF8000, 1, 0, 0, 0);
    conv(32'h7F800000, 1, 0, 1, 5'd0);  chk("R8 +inf s32", 32'h7FFFFFFF, 1, 0, 1, 0);
    conv(32'h477FFF00, 1, 1, 0, 5'd16); chk("R6 R3 65535 u16 zext", 32'h0000FFFF, 1, 0, 0, 0);
  endtask

  task automatic t_unsigned_neg;
    conv(32'hC0400000, 1, 1, 1, 5'd31); chk("R9 -3.0 u32", 32'h00000000, 1, 0, 1, 0);
    conv(32'hBE800000, 1, 1, 0, 5'd16); chk("R9 -0.25 u16", 32'h00000000, 1, 0, 0, 1);
    conv(32'hC0300000, 1, 0, 0, 5'd16); chk("R3 R6 -2.75 s16 sext", 32'hFFFFFFFE, 1, 0, 0, 1);
  endtask

  task automatic t_nan;
    conv(32'h7FC00000, 1, 0, 1, 5'd4);  chk("R9 NaN", 32'h00000000, 1, 0, 1, 0);
  endtask

  task automatic t_half;
    conv(32'hDEAD3E00, 0, 0, 0, 5'd12); chk("R7 half 1.5 upper ignored", 32'h00000018, 1, 0, 0, 0);
    conv(32'h0000C500, 0, 0, 1, 5'd16); chk("R7 half -5.0 s32 f16", 32'hFFFB0000, 1, 0, 0, 0);
  endtask

  task automatic t_illegal;
    conv(32'h40400000, 1, 0, 1, 5'd31); chk("R5 setup", 32'h00000006, 1, 0, 0, 0);
    conv(32'h7F800000, 1, 0, 0, 5'd17); chk("R5 illegal imm17", 32'h00000006, 0, 1, 0, 0);
    conv(32'h3F800000, 1, 0, 0, 5'd16); chk("R5 imm16 legal", 32'h00000001, 1, 0, 0, 0);
  endtask

  task automatic t_subnormal;
    conv(32'h00000000, 1, 0, 1, 5'd0);  chk("R10 zero", 32'h00000000, 1, 0, 0, 0);
    conv(32'h00000001, 1, 0, 1, 5'd0);  chk("R10 tiny subnormal", 32'h00000000, 1, 0, 0, 1);
    conv(32'h00000200, 0, 0, 0, 5'd0);  chk("R10 half subnormal f16", 32'h00000002, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_basic();
    t_trunc();
    t_sat();
    t_unsigned_neg();
    t_nan();
    t_half();
    t_illegal();
    t_subnormal();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule